// File: doc/BRIEF.md
# Shader Thread-Group Sequencer

This block keeps a table of thread groups (64 threads each) that are live in a shader core and decides, every cycle, which one group sends its next instruction down the shared ALU pipeline. A launcher places a new group into a free slot and tags it with a work-stream type. Instruction decode sits outside the block. In the same cycle that a group issues, decode reports two things: whether the instruction starts a request whose latency has no bound, and whether it is the group's final instruction.

A group that starts such a request is announced on the request output. It then sleeps and takes no part in arbitration until a wake carrying its slot number comes back. A group that issues its final instruction gives up its slot. The ALU works on a pair of groups in alternation, so no group issues on two cycles in a row. A software-written policy register selects round-robin or oldest-first selection, and can also give one stream type precedence.

Top module: `thread_sequencer`

## Requirements
- R1: After reset every slot is free (`freeMask` all ones), and `issueValid` and `reqValid` are low.
- R2: A launch into a free slot makes that slot busy from the next cycle, and it may issue in that cycle. A launch into a busy slot has no effect: an asleep group stays asleep, and the slot keeps its stream tag.
- R3: Only ready groups issue. The same slot never issues on two consecutive cycles. If the only ready group issued in the previous cycle, the current cycle is a bubble (`issueValid` low).
- R4: When `issueFetch` is high in an issue cycle, `reqValid` is high in that same cycle with `reqSlot` equal to `issueSlot`. From the next cycle the group is asleep and does not issue.
- R5: A wake to an asleep slot makes it ready in the next cycle. A wake to a slot that is not asleep is ignored.
- R6: When `issueLast` is high in an issue cycle, the slot is free from the next cycle. A launch to that slot in the same cycle is ignored. A launch in the next cycle is accepted.
- R7: Policy bit 0 = 0 selects round-robin. The grant goes to the first candidate found by scanning upward from the slot after the last granted slot, wrapping at the top. After reset the scan starts at slot 0.
- R8: Policy bit 0 = 1 selects oldest-first. The candidate launched earliest wins.
- R9: When policy bit 1 = 1 and at least one eligible group has a stream tag equal to policy bit 2, only those groups are candidates. Otherwise all eligible groups are candidates.
- R10: In a cycle with no ready group, `issueValid` is low and the round-robin position does not move.
- R11: A policy write takes effect from the cycle after `cfgWe`. Reset value is 0 (round-robin, no stream priority).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch a new group |
| launchSlot | input | 4 | Target slot of the launch |
| launchStream | input | 1 | Stream-type tag of the launched group |
| cfgWe | input | 1 | Write enable for the policy register |
| cfgPolicy | input | 3 | Policy: bit0 oldest-first, bit1 stream priority on, bit2 favoured stream |
| wakeValid | input | 1 | A long-latency request has completed |
| wakeSlot | input | 4 | Slot whose request completed |
| issueFetch | input | 1 | Issued instruction starts an unbounded-latency request |
| issueLast | input | 1 | Issued instruction is the group's last |
| issueValid | output | 1 | A group issues this cycle |
| issueSlot | output | 4 | Slot of the issuing group |
| reqValid | output | 1 | Resource request this cycle |
| reqSlot | output | 4 | Slot making the request |
| freeMask | output | 16 | One bit per slot, high when the slot is free |

## Verification
A corrupt slot state appears at the issue port within one or two cycles. A group that should sleep issues again, a woken group never returns, or a freed slot keeps issuing or stays missing from `freeMask`. A wrong age order, a misplaced round-robin pointer or a wrongly latched policy changes which slot number appears on the first contested grant. The bench therefore builds contests among three ready groups in which each policy picks a different winner, and it compares the issued slot and the request pair on every cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_READY  = 2'd1,
    SLOT_ASLEEP = 2'd2
  } slotState_e;

  // policy register layout; bit positions are seen by software
  typedef struct packed {
    logic favStream;   // bit 2
    logic prioEn;      // bit 1
    logic oldestFirst; // bit 0
  } policy_t;

  // strobes from the arbiter to the slot table
  typedef struct packed {
    logic grant;
    logic sleep;
    logic retire;
  } tsStrobe_t;

endpackage

// File: rtl/ts_slot_table.sv
module ts_slot_table
  import ts_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  launchValid,
  input  logic [IDX_W-1:0]                      launchSlot,
  input  logic                                  launchStream,
  input  logic                                  wakeValid,
  input  logic [IDX_W-1:0]                      wakeSlot,
  input  tsStrobe_t                             ctl,
  input  logic [IDX_W-1:0]                      ctlSlot,
  output logic [NUM_SLOTS-1:0]                  readyMask,
  output logic [NUM_SLOTS-1:0]                  freeMask,
  output logic [NUM_SLOTS-1:0]                  streamMask,
  output logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]   olderMat
);

  slotState_e slotState [NUM_SLOTS];
  logic       launchOk;

  assign launchOk = launchValid && (slotState[launchSlot] == SLOT_FREE);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hitGrant, hitLaunch, hitWake;
    assign hitGrant  = ctl.grant && (ctlSlot == IDX_W'(s));
    assign hitLaunch = launchOk && (launchSlot == IDX_W'(s));
    assign hitWake   = wakeValid && (wakeSlot == IDX_W'(s)) &&
                       (slotState[s] == SLOT_ASLEEP);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotState[s]  <= SLOT_FREE;
        streamMask[s] <= 1'b0;
      end else if (hitGrant) begin
        if (ctl.retire)     slotState[s] <= SLOT_FREE;
        else if (ctl.sleep) slotState[s] <= SLOT_ASLEEP;
      end else if (hitLaunch) begin
        slotState[s]  <= SLOT_READY;
        streamMask[s] <= launchStream;
      end else if (hitWake) begin
        slotState[s] <= SLOT_READY;
      end
    end

    // row s: bit j set when slot s was launched before slot j
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        olderMat[s] <= '0;
      end else if (hitLaunch) begin
        olderMat[s] <= '0;
      end else if (launchOk) begin
        olderMat[s][launchSlot] <= 1'b1;
      end
    end

    assign readyMask[s] = (slotState[s] == SLOT_READY);
    assign freeMask[s]  = (slotState[s] == SLOT_FREE);
  end

  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant |-> slotState[ctlSlot] == SLOT_READY);

  p_sleep_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant && ctl.sleep && !ctl.retire |=> slotState[$past(ctlSlot)] == SLOT_ASLEEP);

  p_wake_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wakeValid && slotState[wakeSlot] == SLOT_ASLEEP |=> slotState[$past(wakeSlot)] == SLOT_READY);

  p_retire_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant && ctl.retire |=> slotState[$past(ctlSlot)] == SLOT_FREE);

endmodule

// File: rtl/ts_arbiter.sv
module ts_arbiter
  import ts_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfgWe,
  input  logic [2:0]                            cfgPolicy,
  input  logic [NUM_SLOTS-1:0]                  readyMask,
  input  logic [NUM_SLOTS-1:0]                  streamMask,
  input  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]   olderMat,
  input  logic                                  issueFetch,
  input  logic                                  issueLast,
  output tsStrobe_t                             ctl,
  output logic [IDX_W-1:0]                      grantSlot
);

  policy_t                policy;
  logic [IDX_W-1:0]       rrPtr;
  logic                   prevValid;
  logic [IDX_W-1:0]       prevSlot;
  logic [NUM_SLOTS-1:0]   prevMask, elig, favMask, cand, hasOlder;
  logic [IDX_W-1:0]       oldPick, rrPick;

  always_comb begin
    prevMask = '0;
    if (prevValid) prevMask[prevSlot] = 1'b1;
  end

  assign elig    = readyMask & ~prevMask;
  assign favMask = elig & (policy.favStream ? streamMask : ~streamMask);
  assign cand    = (policy.prioEn && |favMask) ? favMask : elig;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_age
    logic [NUM_SLOTS-1:0] col;
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
      assign col[j] = olderMat[j][i];
    end
    assign hasOlder[i] = |(cand & col);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    oldPick = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && cand[i] && !hasOlder[i]) begin
        found   = 1'b1;
        oldPick = IDX_W'(i);
      end
    end
  end

  always_comb begin
    logic found;
    int   idx;
    found  = 1'b0;
    rrPick = '0;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      idx = (int'(rrPtr) + k) % NUM_SLOTS;
      if (!found && cand[idx]) begin
        found  = 1'b1;
        rrPick = IDX_W'(idx);
      end
    end
  end

  assign grantSlot  = policy.oldestFirst ? oldPick : rrPick;
  assign ctl.grant  = |cand;
  assign ctl.sleep  = ctl.grant && issueFetch;
  assign ctl.retire = ctl.grant && issueLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      policy    <= '0;
      rrPtr     <= IDX_W'(NUM_SLOTS - 1);
      prevValid <= 1'b0;
      prevSlot  <= '0;
    end else begin
      if (cfgWe) policy <= policy_t'(cfgPolicy);
      prevValid <= ctl.grant;
      if (ctl.grant) begin
        rrPtr    <= grantSlot;
        prevSlot <= grantSlot;
      end
    end
  end

  p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant && $past(ctl.grant) |-> grantSlot != $past(grantSlot));

  p_grant_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant |-> readyMask[grantSlot]);

  p_fav_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.grant && policy.prioEn && |(readyMask & ~prevMask & (policy.favStream ? streamMask : ~streamMask))
      |-> streamMask[grantSlot] == policy.favStream);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|readyMask) |=> $stable(rrPtr));

endmodule

// File: rtl/thread_sequencer.sv
module thread_sequencer
  import ts_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launchValid,
  input  logic [IDX_W-1:0]     launchSlot,
  input  logic                 launchStream,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgPolicy,
  input  logic                 wakeValid,
  input  logic [IDX_W-1:0]     wakeSlot,
  input  logic                 issueFetch,
  input  logic                 issueLast,
  output logic                 issueValid,
  output logic [IDX_W-1:0]     issueSlot,
  output logic                 reqValid,
  output logic [IDX_W-1:0]     reqSlot,
  output logic [NUM_SLOTS-1:0] freeMask
);

  tsStrobe_t                            ctl;
  logic [IDX_W-1:0]                     grantSlot;
  logic [NUM_SLOTS-1:0]                 readyMask, streamMask;
  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]  olderMat;

  ts_slot_table #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) table_i (
    .clk, .rst_n, .launchValid, .launchSlot, .launchStream,
    .wakeValid, .wakeSlot, .ctl, .ctlSlot(grantSlot),
    .readyMask, .freeMask, .streamMask, .olderMat
  );

  ts_arbiter #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) arb_i (
    .clk, .rst_n, .cfgWe, .cfgPolicy, .readyMask, .streamMask, .olderMat,
    .issueFetch, .issueLast, .ctl, .grantSlot
  );

  assign issueValid = ctl.grant;
  assign issueSlot  = grantSlot;
  assign reqValid   = ctl.sleep;
  assign reqSlot    = grantSlot;

endmodule

// File: tb/thread_sequencer_tb.sv
`timescale 1ns/1ps
module thread_sequencer_tb_top;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         launchValid = 1'b0;
  logic [3:0]   launchSlot = '0;
  logic         launchStream = 1'b0;
  logic         cfgWe = 1'b0;
  logic [2:0]   cfgPolicy = '0;
  logic         wakeValid = 1'b0;
  logic [3:0]   wakeSlot = '0;
  logic         issueFetch = 1'b0;
  logic         issueLast = 1'b0;
  logic         issueValid, reqValid;
  logic [3:0]   issueSlot, reqSlot;
  logic [N-1:0] freeMask;

  int nTests = 0;
  int nFail  = 0;

  typedef struct {
    bit    ev;
    int    es;
    bit    f;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  thread_sequencer #(.NUM_SLOTS(N)) dut_i (
    .clk, .rst_n, .launchValid, .launchSlot, .launchStream, .cfgWe, .cfgPolicy,
    .wakeValid, .wakeSlot, .issueFetch, .issueLast,
    .issueValid, .issueSlot, .reqValid, .reqSlot, .freeMask
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle once settled after the negedge
  always begin
    @(negedge clk);
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      int actCode, expCode;
      it = expQ.pop_front();
      actCode = issueValid ? int'(issueSlot) : -1;
      expCode = it.ev ? it.es : -1;
      check(actCode == expCode, it.req, "issue slot (-1 = none)", actCode, expCode);
      actCode = reqValid ? int'(reqSlot) : -1;
      expCode = (it.ev && it.f) ? it.es : -1;
      check(actCode == expCode, it.req, "request slot (-1 = none)", actCode, expCode);
    end
  end

  task automatic launch(input int slot, input bit stream);
    launchValid  = 1'b1;
    launchSlot   = 4'(slot);
    launchStream = stream;
  endtask

  task automatic wake(input int slot);
    wakeValid = 1'b1;
    wakeSlot  = 4'(slot);
  endtask

  task automatic setPolicy(input logic [2:0] p);
    cfgWe     = 1'b1;
    cfgPolicy = p;
  endtask

  // one cycle: push the expectation, drive decode flags, advance
  task automatic cyc(input bit ev, input int es, input bit f, input bit l, input string req);
    expItem_t it;
    it.ev = ev; it.es = es; it.f = f; it.req = req;
    expQ.push_back(it);
    issueFetch = f;
    issueLast  = l;
    @(posedge clk);
    #0.5;
    launchValid = 1'b0;
    wakeValid   = 1'b0;
    cfgWe       = 1'b0;
    issueFetch  = 1'b0;
    issueLast   = 1'b0;
    @(negedge clk);
  endtask

  task automatic chkFree(input int slot, input bit exp, input string req);
    check(freeMask[slot] == exp, req, $sformatf("freeMask[%0d]", slot), int'(freeMask[slot]), int'(exp));
  endtask

  task automatic chkAllFree(input string req);
    check(&freeMask, req, "all slots free", int'(freeMask), 16'hFFFF);
  endtask

  initial begin
    #(5.0 * 20000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chkAllFree("R1");
    check(!issueValid, "R1", "issueValid", int'(issueValid), 0);
    check(!reqValid, "R1", "reqValid", int'(reqValid), 0);

    // lone group: launch, alternating bubbles (R2, R3)
    launch(3, 0);            cyc(0, 0, 0, 0, "R2");
    chkFree(3, 0, "R2");     cyc(1, 3, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 3, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    // fetch -> sleep (R4), ignored wake/launch (R5, R2)
    cyc(1, 3, 1, 0, "R4");
    cyc(0, 0, 0, 0, "R4");
    wake(5); launch(3, 1);   cyc(0, 0, 0, 0, "R5");
    chkFree(5, 1, "R5");
    wake(3);                 cyc(0, 0, 0, 0, "R2");
    launch(3, 0);            cyc(1, 3, 0, 1, "R5");
    // retire and relaunch (R6)
    chkFree(3, 1, "R6");
    launch(3, 0);            cyc(0, 0, 0, 0, "R6");
    cyc(1, 3, 0, 1, "R6");
    chkAllFree("R6");        cyc(0, 0, 0, 0, "R6");

    // round-robin rotation (R7)
    launch(1, 0);            cyc(0, 0, 0, 0, "R7");
    launch(2, 0);            cyc(1, 1, 0, 0, "R7");
    launch(5, 0);            cyc(1, 2, 0, 0, "R7");
    cyc(1, 5, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R7");
    cyc(1, 2, 0, 0, "R7");
    cyc(1, 5, 0, 0, "R7");
    cyc(1, 1, 1, 0, "R4");
    cyc(1, 2, 1, 0, "R4");
    cyc(1, 5, 1, 0, "R4");
    // idle cycles keep the pointer (R10)
    cyc(0, 0, 0, 0, "R10");
    wake(1); launch(7, 0);   cyc(0, 0, 0, 0, "R10");
    cyc(1, 7, 0, 0, "R10");
    cyc(1, 1, 0, 0, "R7");
    cyc(1, 7, 0, 1, "R6");
    wake(2);                 cyc(1, 1, 0, 1, "R6");
    wake(5);                 cyc(1, 2, 0, 1, "R5");
    cyc(1, 5, 0, 1, "R5");
    chkAllFree("R6");

    // oldest-first (R8) and delayed policy write (R11)
    setPolicy(3'b001); launch(9, 0);  cyc(0, 0, 0, 0, "R11");
    launch(4, 0);            cyc(1, 9, 0, 0, "R8");
    launch(12, 0);           cyc(1, 4, 0, 0, "R8");
    cyc(1, 9, 0, 0, "R8");
    cyc(1, 4, 0, 0, "R8");
    cyc(1, 9, 0, 0, "R8");
    setPolicy(3'b000);       cyc(1, 4, 0, 0, "R11");
    cyc(1, 9, 0, 0, "R11");
    cyc(1, 12, 0, 0, "R7");
    cyc(1, 4, 0, 0, "R7");
    cyc(1, 9, 0, 1, "R7");
    cyc(1, 12, 0, 1, "R7");
    cyc(1, 4, 0, 1, "R7");

    // stream priority (R9)
    setPolicy(3'b110); launch(6, 0);  cyc(0, 0, 0, 0, "R9");
    launch(10, 1);           cyc(1, 6, 0, 0, "R9");
    launch(11, 1);           cyc(1, 10, 0, 0, "R9");
    cyc(1, 11, 0, 0, "R9");
    cyc(1, 10, 0, 0, "R9");
    cyc(1, 11, 0, 0, "R9");
    setPolicy(3'b010);       cyc(1, 10, 0, 0, "R11");
    cyc(1, 6, 0, 0, "R9");
    cyc(1, 10, 0, 0, "R9");
    cyc(1, 6, 0, 0, "R9");
    cyc(1, 10, 0, 1, "R9");
    cyc(1, 6, 0, 1, "R9");
    cyc(1, 11, 0, 1, "R9");
    chkAllFree("R6");        cyc(0, 0, 0, 0, "R10");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule